// File: doc/BRIEF.md
# PCI Window Control Register File

This block is the programmable register bank of a PCI host bridge. It keeps, per address window, a base register, a mask register and a translated-base register. It also keeps one bridge control register. All of these are reached through a simple request/response bus that carries only full 64-bit accesses. The window registers and the control register are also driven out continuously, so that an address translator beside the block can compare bus addresses against the windows with no bus traffic.

Registers are spaced 64 bytes apart. The six low address bits play no part in selecting a register. The bank also answers a small set of stub offsets. The error status and error mask read as zero. Error status and the invalidate-all TLB command accept writes and drop them. Offsets reserved for error injection, per-address TLB invalidation, performance monitoring and latency tuning are not built, and any access to them reports an error, as does any offset outside the map. Every request gets exactly one response pulse after a fixed, parameterised latency.

Top module: `pci_win_regfile`

## Requirements
- R1: The register index is (reqAddr - BASE_ADDR) >> 6, and address bits [5:0] are ignored. With NUM_WIN = 4 the map is: 0-3 window base, 4-7 window mask, 8-11 translated base, 12 control, 13 error status, 14 error mask, 15 invalidate-all TLB, 16-21 unimplemented, 22 and up unmapped.
- R2: reqSize encodes the access width as log2 of its bytes (0 = 1, 1 = 2, 2 = 4, 3 = 8). Any size other than 3 raises rspErr and changes no register.
- R3: Every window base, mask and translated-base register is 64 bits wide and fully writable. It reads back what was written, and it shows the same value on its slice of winBase, winMask or winXlat (window i at bits [64*i+63:64*i]).
- R4: After reset the control register holds 64'h0000_0021_0010_0000 (bit 20 set, bit 32 set, value 2 in the field from bit 36). It is fully writable and is shown on bridgeCtrl.
- R5: After reset every window register is zero.
- R6: The error status and error mask registers read as zero without error. A write to error status is accepted with no error and no effect. A write to error mask raises rspErr.
- R7: A write to the invalidate-all TLB offset is accepted with no error, and its data is discarded. A read of it returns zero.
- R8: An access to an unimplemented offset, an unmapped offset or an address below BASE_ADDR raises rspErr and changes no register.
- R9: Each request accepted at a clock edge produces exactly one rspValid pulse, one cycle wide, RSP_LAT cycles later. rspErr is only ever high together with rspValid. rspRdata is zero for writes and for errored accesses.
- R10: A read returns the register contents from before the edge that accepts it. A write issued in the next cycle does not change a response that is already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqSize | input | 2 | log2 of access width in bytes |
| reqWdata | input | 64 | Write data |
| rspValid | output | 1 | One-cycle response strobe |
| rspErr | output | 1 | Request rejected (valid with rspValid) |
| rspRdata | output | 64 | Read data (valid with rspValid) |
| winBase | output | NUM_WIN*64 | All window base registers |
| winMask | output | NUM_WIN*64 | All window mask registers |
| winXlat | output | NUM_WIN*64 | All translated-base registers |
| bridgeCtrl | output | 64 | Bridge control register |

## Verification
A read response and a register update can fall in the same cycle. The bench issues a read of a window register in one cycle and a write to that same register in the very next cycle. The read's response then emerges on the same clock edge that commits the write. The check is that the response carries the old contents, while the exported port already shows the new value one cycle later. The same overlap is provoked for the control register. Around it, the bench sweeps every index of the map under every access size, in both directions.

// File: rtl/pci_win_pkg.sv
package pci_win_pkg;

  localparam logic [1:0] SZ_DWORD = 2'd3;
  localparam logic [63:0] CTRL_RESET = 64'h0000_0021_0010_0000;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_BASE,
    RD_MASK,
    RD_XLAT,
    RD_CTRL
  } rdSrc_e;

  typedef struct packed {
    logic       fire;
    logic       fault;
    logic       wrBase;
    logic       wrMask;
    logic       wrXlat;
    logic       wrCtrl;
    rdSrc_e     rdSrc;
    logic [7:0] winSel;
  } regStrobe_t;

endpackage

// File: rtl/pci_win_ctrl.sv
module pci_win_ctrl
  import pci_win_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8000_0000,
  parameter int NUM_WIN = 4
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  output regStrobe_t        stb
);

  localparam int IDX_W = ADDR_W - 6;
  localparam logic [IDX_W-1:0] IX_MASK0 = IDX_W'(NUM_WIN);
  localparam logic [IDX_W-1:0] IX_XLAT0 = IDX_W'(2 * NUM_WIN);
  localparam logic [IDX_W-1:0] IX_CTRL  = IDX_W'(3 * NUM_WIN);
  localparam logic [IDX_W-1:0] IX_ERR   = IDX_W'(3 * NUM_WIN + 1);
  localparam logic [IDX_W-1:0] IX_EMASK = IDX_W'(3 * NUM_WIN + 2);
  localparam logic [IDX_W-1:0] IX_TLBALL = IDX_W'(3 * NUM_WIN + 3);

  logic [ADDR_W-1:0] offset;
  logic [IDX_W-1:0]  regIdx;
  logic [IDX_W-1:0]  grpOff;

  always_comb begin
    offset = reqAddr - BASE_ADDR;
    regIdx = offset[ADDR_W-1:6];
    grpOff = '0;
    stb = '0;
    stb.rdSrc = RD_ZERO;
    stb.fire = reqValid;
    if (reqAddr < BASE_ADDR || reqSize != SZ_DWORD) begin
      stb.fault = 1'b1;
    end else if (regIdx < IX_MASK0) begin
      grpOff = regIdx;
      if (reqWrite) stb.wrBase = 1'b1;
      else stb.rdSrc = RD_BASE;
    end else if (regIdx < IX_XLAT0) begin
      grpOff = regIdx - IX_MASK0;
      if (reqWrite) stb.wrMask = 1'b1;
      else stb.rdSrc = RD_MASK;
    end else if (regIdx < IX_CTRL) begin
      grpOff = regIdx - IX_XLAT0;
      if (reqWrite) stb.wrXlat = 1'b1;
      else stb.rdSrc = RD_XLAT;
    end else if (regIdx == IX_CTRL) begin
      if (reqWrite) stb.wrCtrl = 1'b1;
      else stb.rdSrc = RD_CTRL;
    end else if (regIdx == IX_ERR || regIdx == IX_TLBALL) begin
      stb.fault = 1'b0;
    end else if (regIdx == IX_EMASK) begin
      stb.fault = reqWrite;
    end else begin
      stb.fault = 1'b1;
    end
    stb.winSel = 8'(grpOff);
    if (!reqValid) begin
      stb.wrBase = 1'b0;
      stb.wrMask = 1'b0;
      stb.wrXlat = 1'b0;
      stb.wrCtrl = 1'b0;
    end
  end

endmodule

// File: rtl/pci_win_datapath.sv
module pci_win_datapath
  import pci_win_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int RSP_LAT = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrobe_t             stb,
  input  logic [63:0]            reqWdata,
  output logic                   rspValid,
  output logic                   rspErr,
  output logic [63:0]            rspRdata,
  output logic [NUM_WIN*64-1:0]  winBase,
  output logic [NUM_WIN*64-1:0]  winMask,
  output logic [NUM_WIN*64-1:0]  winXlat,
  output logic [63:0]            bridgeCtrl
);

  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [63:0] baseR [NUM_WIN];
  logic [63:0] maskR [NUM_WIN];
  logic [63:0] xlatR [NUM_WIN];
  logic [63:0] ctrlR;
  logic [63:0] rdData;
  logic [WIN_W-1:0] sel;

  logic [RSP_LAT-1:0] vPipe;
  logic [RSP_LAT-1:0] ePipe;
  logic [63:0]        dPipe [RSP_LAT];

  assign sel = stb.winSel[WIN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        baseR[i] <= '0;
        maskR[i] <= '0;
        xlatR[i] <= '0;
      end
      ctrlR <= CTRL_RESET;
    end else begin
      if (stb.wrBase) baseR[sel] <= reqWdata;
      if (stb.wrMask) maskR[sel] <= reqWdata;
      if (stb.wrXlat) xlatR[sel] <= reqWdata;
      if (stb.wrCtrl) ctrlR <= reqWdata;
    end
  end

  always_comb begin
    case (stb.rdSrc)
      RD_BASE: rdData = baseR[sel];
      RD_MASK: rdData = maskR[sel];
      RD_XLAT: rdData = xlatR[sel];
      RD_CTRL: rdData = ctrlR;
      default: rdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vPipe <= '0;
      ePipe <= '0;
      for (int i = 0; i < RSP_LAT; i++) dPipe[i] <= '0;
    end else begin
      vPipe[0] <= stb.fire;
      ePipe[0] <= stb.fire & stb.fault;
      dPipe[0] <= stb.fire ? rdData : 64'd0;
      for (int i = 1; i < RSP_LAT; i++) begin
        vPipe[i] <= vPipe[i-1];
        ePipe[i] <= ePipe[i-1];
        dPipe[i] <= dPipe[i-1];
      end
    end
  end

  assign rspValid = vPipe[RSP_LAT-1];
  assign rspErr   = ePipe[RSP_LAT-1];
  assign rspRdata = dPipe[RSP_LAT-1];
  assign bridgeCtrl = ctrlR;

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_export
      assign winBase[w*64 +: 64] = baseR[w];
      assign winMask[w*64 +: 64] = maskR[w];
      assign winXlat[w*64 +: 64] = xlatR[w];
    end
  endgenerate

endmodule

// File: rtl/pci_win_regfile.sv
module pci_win_regfile
  import pci_win_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8000_0000,
  parameter int NUM_WIN = 4,
  parameter int RSP_LAT = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [1:0]            reqSize,
  input  logic [63:0]           reqWdata,
  output logic                  rspValid,
  output logic                  rspErr,
  output logic [63:0]           rspRdata,
  output logic [NUM_WIN*64-1:0] winBase,
  output logic [NUM_WIN*64-1:0] winMask,
  output logic [NUM_WIN*64-1:0] winXlat,
  output logic [63:0]           bridgeCtrl
);

  regStrobe_t stb;

  pci_win_ctrl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_WIN(NUM_WIN)
  ) u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqSize(reqSize), .stb(stb)
  );

  pci_win_datapath #(
    .NUM_WIN(NUM_WIN), .RSP_LAT(RSP_LAT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .winBase(winBase), .winMask(winMask), .winXlat(winXlat),
    .bridgeCtrl(bridgeCtrl)
  );

endmodule

// File: rtl/pci_win_regfile_chk.sv
module pci_win_regfile_chk
  import pci_win_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8000_0000,
  parameter int NUM_WIN = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic                  reqWrite,
  input logic [ADDR_W-1:0]     reqAddr,
  input logic [1:0]            reqSize,
  input logic [63:0]           reqWdata,
  input logic                  rspValid,
  input logic                  rspErr,
  input logic [NUM_WIN*64-1:0] winBase,
  input logic [NUM_WIN*64-1:0] winMask,
  input logic [NUM_WIN*64-1:0] winXlat,
  input logic [63:0]           bridgeCtrl
);

  logic [31:0] issued;
  logic [31:0] answered;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      issued <= '0;
      answered <= '0;
    end else begin
      issued <= issued + 32'(reqValid);
      answered <= answered + 32'(rspValid);
    end
  end

  a_r9_err_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid);

  a_r9_no_orphan_rsp: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (issued != answered));

  a_r2_bad_size_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize != SZ_DWORD) |=>
      ($stable(winBase) && $stable(winMask) && $stable(winXlat) && $stable(bridgeCtrl)));

  a_r8_below_base_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr < BASE_ADDR) |=>
      ($stable(winBase) && $stable(winMask) && $stable(winXlat) && $stable(bridgeCtrl)));

  a_r3_base0_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqSize == SZ_DWORD && reqAddr == BASE_ADDR) |=>
      (winBase[63:0] == $past(reqWdata)));

  a_r5_reset_values: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (winBase == '0 && winMask == '0 && winXlat == '0));

  a_r4_reset_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (bridgeCtrl == CTRL_RESET));

endmodule

bind pci_win_regfile pci_win_regfile_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_WIN(NUM_WIN)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
  .rspValid(rspValid), .rspErr(rspErr), .winBase(winBase),
  .winMask(winMask), .winXlat(winXlat), .bridgeCtrl(bridgeCtrl)
);

// File: tb/sim_pci_win_regfile.sv
`timescale 1ns/1ps
module sim_pci_win_regfile;

  localparam int AW = 32;
  localparam logic [AW-1:0] BASE = 32'h8000_0000;
  localparam int NW = 4;
  localparam int LAT = 1;
  localparam logic [63:0] CTRL_RST = 64'h0000_0021_0010_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0] reqSize = 2'd3;
  logic [63:0] reqWdata = '0;
  logic rspValid, rspErr;
  logic [63:0] rspRdata;
  logic [NW*64-1:0] winBase, winMask, winXlat;
  logic [63:0] bridgeCtrl;

  int checks = 0;
  int failures = 0;

  logic [63:0] mBase [NW];
  logic [63:0] mMask [NW];
  logic [63:0] mXlat [NW];
  logic [63:0] mCtrl;

  always #10 clk = ~clk;

  pci_win_regfile #(.ADDR_W(AW), .BASE_ADDR(BASE), .NUM_WIN(NW), .RSP_LAT(LAT)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .winBase(winBase), .winMask(winMask), .winXlat(winXlat),
    .bridgeCtrl(bridgeCtrl)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] modelRead(input int idx);
    if (idx < NW) return mBase[idx];
    if (idx < 2*NW) return mMask[idx-NW];
    if (idx < 3*NW) return mXlat[idx-2*NW];
    if (idx == 3*NW) return mCtrl;
    return 64'd0;
  endfunction

  function automatic bit modelErr(input bit wr, input int idx, input logic [1:0] sz);
    if (sz != 2'd3) return 1'b1;
    if (idx < 0) return 1'b1;
    if (idx <= 3*NW + 1) return 1'b0;
    if (idx == 3*NW + 2) return wr;
    if (idx == 3*NW + 3) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string tagFor(input int idx, input logic [1:0] sz);
    if (sz != 2'd3) return "R2";
    if (idx < 0) return "R8";
    if (idx < 3*NW) return "R3";
    if (idx == 3*NW) return "R4";
    if (idx <= 3*NW + 2) return "R6";
    if (idx == 3*NW + 3) return "R7";
    return "R8";
  endfunction

  task automatic modelWrite(input int idx, input logic [63:0] d);
    if (idx < NW) mBase[idx] = d;
    else if (idx < 2*NW) mMask[idx-NW] = d;
    else if (idx < 3*NW) mXlat[idx-2*NW] = d;
    else if (idx == 3*NW) mCtrl = d;
  endtask

  task automatic checkPorts(input string tag);
    for (int w = 0; w < NW; w++) begin
      chk(winBase[w*64 +: 64] == mBase[w], {tag, " winBase"}, winBase[w*64 +: 64], mBase[w]);
      chk(winMask[w*64 +: 64] == mMask[w], {tag, " winMask"}, winMask[w*64 +: 64], mMask[w]);
      chk(winXlat[w*64 +: 64] == mXlat[w], {tag, " winXlat"}, winXlat[w*64 +: 64], mXlat[w]);
    end
    chk(bridgeCtrl == mCtrl, {tag, " bridgeCtrl"}, bridgeCtrl, mCtrl);
  endtask

  // One access, response sampled LAT cycles after the accepting edge, mid-cycle.
  task automatic access(input bit wr, input int idx, input int lowOff, input logic [1:0] sz,
                        input logic [63:0] wd);
    string tag;
    bit expE;
    logic [63:0] expD;
    tag = tagFor(idx, sz);
    expE = modelErr(wr, idx, sz);
    expD = (wr || expE) ? 64'd0 : modelRead(idx);
    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr = BASE + AW'(idx * 64) + AW'(lowOff);
    reqSize = sz;
    reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    chk(rspValid == 1'b1, {tag, " R9 rspValid"}, 64'(rspValid), 64'd1);
    chk(rspErr == expE, {tag, " rspErr"}, 64'(rspErr), 64'(expE));
    chk(rspRdata == expD, {tag, " rspRdata"}, rspRdata, expD);
    if (wr && !expE) modelWrite(idx, wd);
    checkPorts(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int w = 0; w < NW; w++) begin
      mBase[w] = '0; mMask[w] = '0; mXlat[w] = '0;
    end
    mCtrl = CTRL_RST;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R5 / R4: reset state
    checkPorts("R5 R4 reset");
    chk(rspValid == 1'b0, "R9 idle after reset", 64'(rspValid), 64'd0);
    access(1'b0, 3*NW, 0, 2'd3, 64'd0);

    // Sweep: every size, every index up to past the map, both directions.
    for (int sz = 0; sz < 4; sz++) begin
      for (int idx = 0; idx < 3*NW + 12; idx++) begin
        logic [63:0] pat;
        pat = {16'(idx), 16'(sz), 32'hC3A5_0F00 ^ 32'(idx * 977)};
        access(1'b1, idx, 0, 2'(sz), pat);
        access(1'b0, idx, 0, 2'(sz), 64'd0);
      end
    end

    // R1: low six address bits ignored
    access(1'b1, 5, 6'h2c, 2'd3, 64'hDEAD_BEEF_0123_4567);
    access(1'b0, 5, 0, 2'd3, 64'd0);
    access(1'b0, 5, 6'h3f, 2'd3, 64'd0);
    chk(winMask[64 +: 64] == 64'hDEAD_BEEF_0123_4567, "R1 stride alias",
        winMask[64 +: 64], 64'hDEAD_BEEF_0123_4567);

    // R8: below base
    access(1'b1, -1, 0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    access(1'b0, -1, 0, 2'd3, 64'd0);

    // R10: read then write of the same register in consecutive cycles
    for (int k = 0; k < 2; k++) begin
      int idx;
      logic [63:0] oldV, newV;
      idx = (k == 0) ? 2 : 3*NW;
      oldV = modelRead(idx);
      newV = 64'h5A5A_0000_0000_0000 | 64'(idx + 1);
      @(negedge clk);
      reqValid = 1'b1; reqWrite = 1'b0; reqSize = 2'd3;
      reqAddr = BASE + AW'(idx * 64);
      @(negedge clk);
      reqWrite = 1'b1; reqWdata = newV;
      chk(rspValid && !rspErr && rspRdata == oldV, "R10 read sees old value", rspRdata, oldV);
      @(negedge clk);
      reqValid = 1'b0;
      chk(rspValid && !rspErr && rspRdata == 64'd0, "R10 write response", rspRdata, 64'd0);
      modelWrite(idx, newV);
      checkPorts("R10 after write");
      @(negedge clk);
      chk(rspValid == 1'b0, "R9 single pulse", 64'(rspValid), 64'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule